// File: doc/BRIEF.md
# Subband Channel Complex Downmixer

This block takes the one-bit output stream of one bandpass sigma-delta modulator in a parallel converter bank and moves that modulator's subband down to zero frequency. Each accepted input bit is turned into a complex sample: a real (I) part and an imaginary (Q) part. The bit selects the sign of a stored cosine value and a stored sine value, so the datapath contains no multiplier.

The carrier is not a free-running tuning word. Software writes two quantized band-edge codes, each in steps of one 1024th of the sample rate. The carrier sits halfway between the two edges, which places it on a grid of one 2048th of the sample rate. The phase sequence therefore repeats exactly and is read from a constant table that is built at elaboration. A load pulse takes in a new pair of edges and restarts the sequence from phase zero. Downstream blocks do the decimation, filtering and re-modulation.

Reset deassertion is expected to be synchronous to `clk`.

Top module: `subband_downmixer`

## Requirements
- R1: While reset is active, and after it ends until the first output, `out_valid_o` is 0 and `i_o`, `q_o` are 0. The phase index and the phase increment both reset to 0, so a sample accepted before any load uses phase 0.
- R2: A sample is accepted when `smp_valid_i` is 1 and `load_i` is 0. Each accepted sample produces exactly one output with `out_valid_o` high, two rising clock edges after the edge that accepts it. No other cycle has `out_valid_o` high.
- R3: An accepted sample is mixed with the current 11-bit phase index p. After that sample, p becomes (p + lo + hi) mod 2048. In a cycle with no accepted sample and no load, p is unchanged.
- R4: A load pulse stores `lo_code_i` and `hi_code_i` and sets p to 0, so the first sample accepted after a load uses phase 0. A sample presented in the same cycle as the load is discarded and produces no output.
- R5: Changes on `lo_code_i` and `hi_code_i` outside a load cycle have no effect on the phase sequence.
- R6: With C[p] ≈ 2047·cos(2πp/2048) and S[p] ≈ 2047·sin(2πp/2048), each within 1 LSB: a bit of 1 gives I = C[p] and Q = −S[p], and a bit of 0 gives I = −C[p] and Q = S[p]. Both outputs are 12-bit two's complement and never equal −2048.
- R7: At the quarter points the table is exact. C = 2047 and S = 0 at p = 0. C = 0 and S = 2047 at p = 512. The signs follow from symmetry at p = 1024 and p = 1536.
- R8: `i_o` and `q_o` hold their last values in every cycle in which `out_valid_o` is 0.
- R9: The phase wraps modulo 2048 for any code pair, including the largest increment, 1023 + 1023 = 2046.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Store the band-edge codes and restart the phase at 0 |
| lo_code_i | input | 10 | Lower band-edge code, units of Fs/1024 |
| hi_code_i | input | 10 | Upper band-edge code, units of Fs/1024 |
| smp_valid_i | input | 1 | Modulator sample strobe |
| smp_bit_i | input | 1 | One-bit modulator sample |
| i_o | output | 12 | Signed real-part output |
| q_o | output | 12 | Signed imaginary-part output |
| out_valid_o | output | 1 | Output sample strobe |

## Verification
Every result of this block arrives a fixed two edges after the edge that accepts its input bit. Each output word depends only on that bit and on the phase index in force at acceptance. The driver records, for each bit it presents, the expected phase from its own model of R3 to R5 and the cycle number at which it drove the bit. The monitor samples on the falling edge and pops one entry for each `out_valid_o`. It requires the cycle count to be exactly two greater than the recorded one, and it compares I and Q against a real-valued cosine and sine. Any valid output when the queue is empty is a failure, and so is any change of the outputs between valid cycles.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

  // Fixed-point scale used while building the table at elaboration
  localparam int FRAC_BITS = 30;
  // pi/2 in Q30
  localparam longint HALF_PI_Q30 = 64'sd1686629713;

  // Quarter-wave sine sample for index idx out of 2**qbits per quarter turn,
  // scaled to +/- amp. Odd Taylor series to x^9 evaluated in Horner form.
  function automatic int quarter_sine(input int idx, input int qbits, input int amp);
    longint one;
    longint x;
    longint x2;
    longint t;
    longint s;
    one = 64'sd1 <<< FRAC_BITS;
    x   = (longint'(idx) * HALF_PI_Q30) >>> qbits;
    x2  = (x * x) >>> FRAC_BITS;
    t   = one - x2 / 72;
    t   = one - ((x2 * t) >>> FRAC_BITS) / 42;
    t   = one - ((x2 * t) >>> FRAC_BITS) / 20;
    t   = one - ((x2 * t) >>> FRAC_BITS) / 6;
    s   = (x * t) >>> FRAC_BITS;
    return int'((s * longint'(amp) + (one >>> 1)) >>> FRAC_BITS);
  endfunction

endpackage

// File: rtl/dm_phase_acc.sv
module dm_phase_acc #(
  parameter int BND_W = 10,
  parameter int PH_W  = BND_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [BND_W-1:0] lo_i,
  input  logic [BND_W-1:0] hi_i,
  input  logic            valid_i,
  input  logic            bit_i,
  output logic            s1_valid_o,
  output logic            s1_bit_o,
  output logic [PH_W-1:0] s1_phase_o
);

  logic [PH_W-1:0] step_q, step_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic            s1_valid_q, s1_valid_d;
  logic            s1_bit_q, s1_bit_d;
  logic [PH_W-1:0] s1_phase_q, s1_phase_d;
  logic            accept;
  logic [PH_W-1:0] code_sum;

  assign accept   = valid_i & ~load_i;
  assign code_sum = PH_W'({1'b0, lo_i}) + PH_W'({1'b0, hi_i});

  always_comb begin
    step_d     = step_q;
    phase_d    = phase_q;
    s1_valid_d = accept;
    s1_bit_d   = s1_bit_q;
    s1_phase_d = s1_phase_q;
    if (load_i) begin
      step_d  = code_sum;
      phase_d = '0;
    end else if (accept) begin
      phase_d = phase_q + step_q;
    end
    if (accept) begin
      s1_bit_d   = bit_i;
      s1_phase_d = phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q     <= '0;
      phase_q    <= '0;
      s1_valid_q <= 1'b0;
      s1_bit_q   <= 1'b0;
      s1_phase_q <= '0;
    end else begin
      step_q     <= step_d;
      phase_q    <= phase_d;
      s1_valid_q <= s1_valid_d;
      s1_bit_q   <= s1_bit_d;
      s1_phase_q <= s1_phase_d;
    end
  end

  assign s1_valid_o = s1_valid_q;
  assign s1_bit_o   = s1_bit_q;
  assign s1_phase_o = s1_phase_q;

  AST_LOAD_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (phase_q == '0)); // R4
  AST_LOAD_DROPS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !s1_valid_q); // R4
  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !load_i) |=> (phase_q == PH_W'($past(phase_q) + $past(step_q)))); // R3
  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && !load_i) |=> $stable(phase_q)); // R3
  AST_STEP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(step_q)); // R5
  AST_S1_PHASE_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !load_i) |=> (s1_phase_q == $past(phase_q))); // R3

endmodule

// File: rtl/dm_trig_lut.sv
module dm_trig_lut #(
  parameter int PH_W  = 11,
  parameter int AMP_W = 12
) (
  input  logic [PH_W-1:0]         phase_i,
  output logic signed [AMP_W-1:0] cos_o,
  output logic signed [AMP_W-1:0] sin_o
);
  import sbd_pkg::*;

  localparam int QB      = PH_W - 2;
  localparam int QN      = 1 << QB;
  localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;

  logic signed [AMP_W-1:0] qtab [0:QN];

  for (genvar g = 0; g <= QN; g++) begin : g_tab
    assign qtab[g] = AMP_W'(quarter_sine(g, QB, AMP_MAX));
  end

  // lane 0: cosine (phase shifted by a quarter turn), lane 1: sine
  logic signed [AMP_W-1:0] lane_val [0:1];

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [PH_W-1:0]  p;
    logic [1:0]       quad;
    logic [QB-1:0]    r;
    logic [QB:0]      idx;
    logic signed [AMP_W-1:0] mag;

    assign p    = (l == 0) ? (phase_i + PH_W'(QN)) : phase_i;
    assign quad = p[PH_W-1 -: 2];
    assign r    = p[QB-1:0];

    always_comb begin
      if (quad[0]) idx = (QB+1)'(QN) - {1'b0, r};
      else         idx = {1'b0, r};
      mag = qtab[idx];
      if (quad[1]) lane_val[l] = -mag;
      else         lane_val[l] = mag;
    end
  end

  assign cos_o = lane_val[0];
  assign sin_o = lane_val[1];

endmodule

// File: rtl/dm_sign_mix.sv
module dm_sign_mix #(
  parameter int AMP_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s1_valid_i,
  input  logic                    s1_bit_i,
  input  logic signed [AMP_W-1:0] cos_i,
  input  logic signed [AMP_W-1:0] sin_i,
  output logic signed [AMP_W-1:0] i_o,
  output logic signed [AMP_W-1:0] q_o,
  output logic                    valid_o
);

  localparam logic signed [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

  logic signed [AMP_W-1:0] i_q, i_d, q_q, q_d;
  logic                    v_q, v_d;

  always_comb begin
    i_d = i_q;
    q_d = q_q;
    v_d = s1_valid_i;
    if (s1_valid_i) begin
      if (s1_bit_i) begin
        i_d = cos_i;
        q_d = -sin_i;
      end else begin
        i_d = -cos_i;
        q_d = sin_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q <= '0;
      q_q <= '0;
      v_q <= 1'b0;
    end else begin
      i_q <= i_d;
      q_q <= q_d;
      v_q <= v_d;
    end
  end

  assign i_o     = i_q;
  assign q_o     = q_q;
  assign valid_o = v_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid_i |=> ($stable(i_q) && $stable(q_q))); // R8
  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid_i |=> v_q); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid_i |=> !v_q); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    v_q |-> ((i_q != MOST_NEG) && (q_q != MOST_NEG))); // R6

endmodule

// File: rtl/subband_downmixer.sv
module subband_downmixer #(
  parameter int BND_W = 10,
  parameter int AMP_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [BND_W-1:0]        lo_code_i,
  input  logic [BND_W-1:0]        hi_code_i,
  input  logic                    smp_valid_i,
  input  logic                    smp_bit_i,
  output logic signed [AMP_W-1:0] i_o,
  output logic signed [AMP_W-1:0] q_o,
  output logic                    out_valid_o
);

  localparam int PH_W = BND_W + 1;

  logic            s1_valid;
  logic            s1_bit;
  logic [PH_W-1:0] s1_phase;
  logic signed [AMP_W-1:0] cos_v, sin_v;

  dm_phase_acc #(.BND_W(BND_W), .PH_W(PH_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .lo_i       (lo_code_i),
    .hi_i       (hi_code_i),
    .valid_i    (smp_valid_i),
    .bit_i      (smp_bit_i),
    .s1_valid_o (s1_valid),
    .s1_bit_o   (s1_bit),
    .s1_phase_o (s1_phase)
  );

  dm_trig_lut #(.PH_W(PH_W), .AMP_W(AMP_W)) u_lut (
    .phase_i (s1_phase),
    .cos_o   (cos_v),
    .sin_o   (sin_v)
  );

  dm_sign_mix #(.AMP_W(AMP_W)) u_mix (
    .clk        (clk),
    .rst_n      (rst_n),
    .s1_valid_i (s1_valid),
    .s1_bit_i   (s1_bit),
    .cos_i      (cos_v),
    .sin_i      (sin_v),
    .i_o        (i_o),
    .q_o        (q_o),
    .valid_o    (out_valid_o)
  );

  AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_i && !load_i) |=> ##1 out_valid_o); // R2

endmodule

// File: tb/test_subband_downmixer.sv
module test_subband_downmixer;

  localparam int CLK_PERIOD = 10;
  localparam int BND_W = 10;
  localparam int AMP_W = 12;
  localparam int NPH   = 2048;

  logic clk = 1'b0;
  logic rst_n;
  logic load_i;
  logic [BND_W-1:0] lo_code_i, hi_code_i;
  logic smp_valid_i, smp_bit_i;
  logic signed [AMP_W-1:0] i_o, q_o;
  logic out_valid_o;

  subband_downmixer #(.BND_W(BND_W), .AMP_W(AMP_W)) i_subband_downmixer (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .lo_code_i   (lo_code_i),
    .hi_code_i   (hi_code_i),
    .smp_valid_i (smp_valid_i),
    .smp_bit_i   (smp_bit_i),
    .i_o         (i_o),
    .q_o         (q_o),
    .out_valid_o (out_valid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    ph;
    bit    b;
    int    cyc;
    string tag;
  } exp_t;

  exp_t  sb[$];
  int    nvec = 0;
  int    nbad = 0;
  int    cyc  = 0;
  int    ph_m = 0;
  int    step_m = 0;
  string cur_tag = "R1";
  int    last_i = 0;
  int    last_q = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit    finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic real absr(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  // monitor: pops the scoreboard on every valid output
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (out_valid_o) begin
        if (sb.size() == 0) begin
          nvec++; nbad++;
          $display("FAIL R2/R4 unexpected output: actual I=%0d Q=%0d expected no output", i_o, q_o);
        end else begin
          exp_t e;
          real ang, ce, se, ei, eq, tol;
          e = sb.pop_front();
          nvec++;
          if (cyc != e.cyc + 2) begin
            nbad++;
            $display("FAIL R2 latency: actual cycle %0d expected %0d", cyc, e.cyc + 2);
          end
          ang = 2.0 * 3.14159265358979 * real'(e.ph) / real'(NPH);
          ce  = 2047.0 * $cos(ang);
          se  = 2047.0 * $sin(ang);
          ei  = e.b ? ce : -ce;
          eq  = e.b ? -se : se;
          tol = ((e.ph % 512) == 0) ? 0.01 : 1.0;   // R7 exact at quarter points
          nvec++;
          if (absr(real'(i_o) - ei) > tol || absr(real'(q_o) - eq) > tol) begin
            nbad++;
            $display("FAIL %s/R6 phase %0d bit %0d: actual I=%0d Q=%0d expected I=%0.2f Q=%0.2f",
                     e.tag, e.ph, e.b, i_o, q_o, ei, eq);
          end
        end
        last_i = i_o;
        last_q = q_o;
      end else begin
        nvec++;
        if (i_o != last_i || q_o != last_q) begin
          nbad++;
          $display("FAIL R8 hold: actual I=%0d Q=%0d expected I=%0d Q=%0d", i_o, q_o, last_i, last_q);
        end
      end
    end
  end

  task automatic send(input bit b, input int gap);
    exp_t e;
    @(negedge clk);
    smp_valid_i = 1'b1;
    smp_bit_i   = b;
    e.ph = ph_m; e.b = b; e.cyc = cyc; e.tag = cur_tag;
    sb.push_back(e);
    ph_m = (ph_m + step_m) % NPH;
    for (int k = 0; k < gap; k++) begin
      @(negedge clk);
      smp_valid_i = 1'b0;
    end
    if (gap == 0) begin
      // next send overrides at the following negedge
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      smp_valid_i = 1'b0;
      load_i = 1'b0;
    end
  endtask

  task automatic do_load(input int lo, input int hi, input bit with_valid);
    @(negedge clk);
    load_i      = 1'b1;
    lo_code_i   = BND_W'(lo);
    hi_code_i   = BND_W'(hi);
    smp_valid_i = with_valid;
    smp_bit_i   = 1'b1;
    step_m = (lo + hi) % NPH;
    ph_m   = 0;
    @(negedge clk);
    load_i      = 1'b0;
    smp_valid_i = 1'b0;
  endtask

  function automatic bit next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog: actual run still active expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; load_i = 1'b0; lo_code_i = '0; hi_code_i = '0;
    smp_valid_i = 1'b0; smp_bit_i = 1'b0;
    repeat (3) @(negedge clk);
    nvec++;
    if (out_valid_o !== 1'b0 || i_o !== '0 || q_o !== '0) begin
      nbad++;
      $display("FAIL R1 reset: actual v=%0b I=%0d Q=%0d expected 0 0 0", out_valid_o, i_o, q_o);
    end
    rst_n = 1'b1;
    idle(2);

    // R1: no load yet, increment is zero, phase stays 0
    cur_tag = "R1";
    send(1'b1, 1); send(1'b0, 1); send(1'b1, 2);
    idle(3);

    // R7: increment 512 walks the quarter points
    cur_tag = "R7";
    do_load(256, 256, 1'b0);
    for (int k = 0; k < 8; k++) send(next_bit(), 1);
    idle(3);

    // R6: subband-like carrier, back-to-back and gapped samples
    cur_tag = "R6";
    do_load(12, 13, 1'b0);
    for (int k = 0; k < 120; k++) send(next_bit(), (k % 3 == 0) ? 3 : 1);
    idle(3);

    // R5: code inputs move without a load
    cur_tag = "R5";
    do_load(200, 207, 1'b0);
    lo_code_i = 10'd5; hi_code_i = 10'd900;
    for (int k = 0; k < 30; k++) send(next_bit(), 1);
    idle(3);

    // R4: sample in the load cycle is dropped, first sample uses phase 0
    cur_tag = "R4";
    do_load(100, 300, 1'b1);
    send(1'b1, 1); send(1'b0, 1); send(1'b1, 1);
    idle(2);
    send(1'b0, 1);
    do_load(40, 41, 1'b1);  // reload mid-stream restarts the phase
    send(1'b1, 1); send(1'b1, 1);
    idle(3);

    // R9: largest increment wraps
    cur_tag = "R9";
    do_load(1023, 1023, 1'b0);
    for (int k = 0; k < 40; k++) send(next_bit(), 1);
    idle(3);

    // R3: long idle gaps keep the phase
    cur_tag = "R3";
    do_load(511, 2, 1'b0);
    for (int k = 0; k < 20; k++) send(next_bit(), 1 + (k % 5) * 4);
    idle(6);

    nvec++;
    if (sb.size() != 0) begin
      nbad++;
      $display("FAIL R2 missing outputs: actual %0d pending expected 0", sb.size());
    end
    finish_run();
  end

endmodule